// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block sits between an internal single-word request port and an external asynchronous static RAM of 256K words by 16 bits. Each accepted request becomes one complete, self-timed pin sequence on the memory side. Chip enable, write enable, output enable, two byte-lane selects and the address are all driven from flops. The data bus is split into an output word, a drive-enable and an input word, and pad logic outside the block resolves them onto the shared wires.

Every timing phase is a whole number of clock cycles. Each phase length is derived from a nanosecond figure and the clock period by rounding up. The phases are address setup, write strobe, write recovery, read access and bus release.

A request is held with `req_valid` until `req_ready` pulses for one cycle, and that pulse completes it. On a read, `rsp_rdata` is valid in the same cycle as the pulse. When the memory has just been reading, a write is delayed until the memory has let go of the bus. Only then does the bridge enable its own data drivers.

Top module: `asram_bridge`

## Requirements
- R1: While reset is held, mem_ce_n, mem_we_n and mem_oe_n are high, both mem_bsel_n bits are high, and mem_dq_oe and req_ready are low.
- R2: A write holds mem_we_n low for exactly WP_CYC cycles, which is 2 at the defaults (ceil(max(7 ns, 5 ns)/4 ns)). mem_oe_n stays high and mem_dq_oe stays high while chip enable is low. A write offered to an idle bridge, with no read in the preceding cycles, sees req_ready on the 5th clock edge after it is offered.
- R3: During an access, mem_bsel_n[0] is low exactly when req_lanes[0] is 1, which selects bits 7:0. mem_bsel_n[1] is low exactly when req_lanes[1] is 1, which selects bits 15:8. A write leaves unselected lanes of the stored word unchanged.
- R4: A read holds mem_oe_n low for RD_CYC cycles, which is 3 at the defaults (ceil(10 ns/4 ns)), with mem_we_n high throughout. rsp_rdata is sampled at the end of that phase. req_ready comes on the 4th edge after an idle offer.
- R5: In rsp_rdata, the byte lanes whose req_lanes bit was 0 read as zero. With req_lanes = 00, the whole word is zero.
- R6: mem_we_n and mem_oe_n are never low together, and mem_dq_oe is never high while mem_oe_n is low.
- R7: If a write follows a read, mem_dq_oe rises no sooner than TA_CYC+1 cycles after mem_oe_n rises, which is 3 at the defaults (TA_CYC = ceil(5 ns/4 ns)). A write offered in the cycle of the read's req_ready therefore completes on the 7th edge.
- R8: A write that is not preceded by a recent read pays no turnaround. Offered in the req_ready cycle of a previous write, it completes on the 6th edge. Offered after at least TA_CYC idle cycles following a read, it completes on the 5th edge.
- R9: req_ready is high for exactly one cycle per request. rsp_rdata keeps its value until the next read completes.
- R10: mem_addr and mem_bsel_n stay constant while mem_ce_n is low. All 18 address bits reach mem_addr, which includes word 0x3FFFF.
- R11: For a write, mem_ce_n stays low for at least ceil(10 ns/4 ns) = 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_bsel_n | output | 2 | Byte-lane selects, active low, bit 0 = lower lane |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The case that matters is a read's bus-release countdown that is still running when the bridge accepts the next write. A write offered in the same cycle that the read returns req_ready makes the two coincide. The bench then measures how many cycles pass between mem_oe_n rising and mem_dq_oe rising, and checks the resulting latency. A memory model that keeps driving the bus for 5 ns after output enable rises flags any cycle in which both sides drive. The write is then read back to show it landed correctly.

// File: rtl/asb_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous SRAM bridge.
// Assumes all timing figures are whole nanoseconds.
package asb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_WSETUP,
        PH_WPULSE,
        PH_WREC,
        PH_RACC,
        PH_DONE
    } phase_t;

    // Smallest cycle count covering a nanosecond minimum.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asb_phase_timer.sv
`timescale 1ns/1ps
// Down-counter used for phase lengths and for the bus-release guard.
// Assumes load has priority; expired is high whenever the count is zero.
module asb_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/asb_seq.sv
`timescale 1ns/1ps
// Phase sequencer: walks each request through its pin phases and
// registers every memory strobe from the next phase so pins never glitch.
// Assumes phase lengths are at least one cycle.
module asb_seq
    import asb_pkg::*;
#(
    parameter int CW        = 4,
    parameter int SETUP_CYC = 1,
    parameter int WP_CYC    = 2,
    parameter int REC_CYC   = 1,
    parameter int RD_CYC    = 3,
    parameter int TA_CYC    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          ph_expired,
    input  logic          rel_clear,
    output logic          ph_load,
    output logic [CW-1:0] ph_val,
    output logic          rel_arm,
    output logic [CW-1:0] rel_val,
    output logic          accept,
    output logic          capture,
    output logic          lanes_on,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          dq_oe,
    output logic          ready
);

    localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] L_WP    = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] L_REC   = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] L_RD    = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] L_TA    = CW'(TA_CYC);

    phase_t phase_q, nxt;

    // Next-phase selection and timer loads.
    always_comb begin
        nxt     = phase_q;
        ph_load = 1'b0;
        ph_val  = '0;
        rel_arm = 1'b0;
        capture = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        if (rel_clear) begin
                            nxt     = PH_WSETUP;
                            ph_load = 1'b1;
                            ph_val  = L_SETUP;
                        end else begin
                            nxt = PH_TURN;
                        end
                    end else begin
                        nxt     = PH_RACC;
                        ph_load = 1'b1;
                        ph_val  = L_RD;
                    end
                end
            end
            PH_TURN: begin
                if (rel_clear) begin
                    nxt     = PH_WSETUP;
                    ph_load = 1'b1;
                    ph_val  = L_SETUP;
                end
            end
            PH_WSETUP: begin
                if (ph_expired) begin
                    nxt     = PH_WPULSE;
                    ph_load = 1'b1;
                    ph_val  = L_WP;
                end
            end
            PH_WPULSE: begin
                if (ph_expired) begin
                    nxt     = PH_WREC;
                    ph_load = 1'b1;
                    ph_val  = L_REC;
                end
            end
            PH_WREC: begin
                if (ph_expired) nxt = PH_DONE;
            end
            PH_RACC: begin
                if (ph_expired) begin
                    nxt     = PH_DONE;
                    capture = 1'b1;
                    rel_arm = 1'b1;
                end
            end
            PH_DONE: nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    assign accept  = (phase_q == PH_IDLE) && req_valid;
    assign rel_val = L_TA;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= nxt;
    end

    // Registered strobes decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n     <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            dq_oe    <= 1'b0;
            lanes_on <= 1'b0;
            ready    <= 1'b0;
        end else begin
            ce_n     <= !(nxt inside {PH_WSETUP, PH_WPULSE, PH_WREC, PH_RACC});
            we_n     <= (nxt != PH_WPULSE);
            oe_n     <= (nxt != PH_RACC);
            dq_oe    <= (nxt inside {PH_WSETUP, PH_WPULSE, PH_WREC});
            lanes_on <= (nxt inside {PH_WSETUP, PH_WPULSE, PH_WREC, PH_RACC});
            ready    <= (nxt == PH_DONE);
        end
    end

endmodule

// File: rtl/asb_lane_path.sv
`timescale 1ns/1ps
// Request holding registers, per-lane select decode and read capture.
// Assumes the data width is a whole number of 8-bit lanes.
module asb_lane_path #(
    parameter int AW    = 18,
    parameter int DW    = 16,
    parameter int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_lanes,
    input  logic             lanes_on,
    input  logic             capture,
    input  logic [DW-1:0]    mem_dq_in,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dq_out,
    output logic [LANES-1:0] mem_bsel_n,
    output logic [DW-1:0]    rsp_rdata
);

    logic [LANES-1:0] lanes_q;
    logic [DW-1:0]    cap_val;

    // Hold the request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            lanes_q    <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            lanes_q    <= req_lanes;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_bsel_n[g]      = !(lanes_on && lanes_q[g]);
        assign cap_val[g*8 +: 8]  = lanes_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    end

    // Capture read data at the end of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (capture) rsp_rdata <= cap_val;
    end

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/1ps
// Asynchronous SRAM bridge top: converts held single-word requests into
// self-timed memory pin sequences. Phase lengths come from nanosecond
// minimums rounded up to whole cycles of CLK_NS.
module asram_bridge
    import asb_pkg::*;
#(
    parameter int AW            = 18,
    parameter int DW            = 16,
    parameter int CLK_NS        = 4,
    parameter int ADDR_SETUP_NS = 1,
    parameter int WR_PULSE_NS   = 7,
    parameter int WR_DSETUP_NS  = 5,
    parameter int WR_CYCLE_NS   = 10,
    parameter int RD_ACCESS_NS  = 10,
    parameter int RD_OE_NS      = 5,
    parameter int OE_RELEASE_NS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_lanes,
    output logic              req_ready,
    output logic [DW-1:0]     rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DW/8-1:0]   mem_bsel_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DW-1:0]     mem_dq_in
);

    localparam int LANES     = DW / 8;
    localparam int SETUP_CYC = imax(1, ns_to_cyc(ADDR_SETUP_NS, CLK_NS));
    localparam int WP_CYC    = imax(1, ns_to_cyc(imax(WR_PULSE_NS, WR_DSETUP_NS), CLK_NS));
    localparam int REC_CYC   = imax(1, ns_to_cyc(WR_CYCLE_NS, CLK_NS) - SETUP_CYC - WP_CYC);
    localparam int RD_CYC    = imax(1, ns_to_cyc(imax(RD_ACCESS_NS, RD_OE_NS), CLK_NS));
    localparam int TA_CYC    = imax(1, ns_to_cyc(OE_RELEASE_NS, CLK_NS));
    localparam int MAX_CYC   = imax(imax(SETUP_CYC, WP_CYC), imax(imax(REC_CYC, RD_CYC), TA_CYC));
    localparam int CW        = imax(1, $clog2(MAX_CYC + 1));

    logic          ph_load, ph_expired, rel_arm, rel_clear;
    logic [CW-1:0] ph_val, rel_val;
    logic          accept, capture, lanes_on;

    asb_seq #(
        .CW(CW), .SETUP_CYC(SETUP_CYC), .WP_CYC(WP_CYC),
        .REC_CYC(REC_CYC), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .ph_expired(ph_expired), .rel_clear(rel_clear),
        .ph_load(ph_load), .ph_val(ph_val),
        .rel_arm(rel_arm), .rel_val(rel_val),
        .accept(accept), .capture(capture), .lanes_on(lanes_on),
        .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
        .dq_oe(mem_dq_oe), .ready(req_ready)
    );

    // Length of the current phase.
    asb_phase_timer #(.CW(CW)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(ph_load), .load_val(ph_val), .expired(ph_expired)
    );

    // Bus-release guard armed when output enable is withdrawn.
    asb_phase_timer #(.CW(CW)) u_release_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(rel_arm), .load_val(rel_val), .expired(rel_clear)
    );

    asb_lane_path #(.AW(AW), .DW(DW), .LANES(LANES)) u_lanes (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .lanes_on(lanes_on), .capture(capture),
        .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_bsel_n(mem_bsel_n), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/asb_checker.sv
`timescale 1ns/1ps
// Protocol checker bound to the bridge. Assumes default clock and write
// pulse figures; the pulse window is measured with a counter.
module asb_checker #(
    parameter int AW          = 18,
    parameter int LANES       = 2,
    parameter int CLK_NS      = 4,
    parameter int WR_PULSE_NS = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_ce_n,
    input logic             mem_we_n,
    input logic             mem_oe_n,
    input logic             mem_dq_oe,
    input logic             req_ready,
    input logic [AW-1:0]    mem_addr,
    input logic [LANES-1:0] mem_bsel_n
);

    localparam int WP_MIN = (WR_PULSE_NS + CLK_NS - 1) / CLK_NS;

    logic [7:0] we_lo_cnt;

    // Count consecutive sampled cycles of write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_lo_cnt <= '0;
        else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
        else                we_lo_cnt <= '0;
    end

    a_r6_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    a_r6_no_drive_while_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |=> (mem_ce_n || ($stable(mem_addr) && $stable(mem_bsel_n))));

    a_r2_we_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt >= 8'(WP_MIN)));

    a_r2_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

endmodule

bind asram_bridge asb_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_oe(mem_dq_oe), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_bsel_n(mem_bsel_n)
);

// File: tb/sim_asram_bridge.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, with a lane-aware memory model
// that has a 10 ns access time and a 5 ns output release tail.
module sim_asram_bridge;

    localparam int WP = 2, RD = 3, TA = 2;
    localparam int WR_LAT = 5, RD_LAT = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_bsel_n;
    logic [17:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hE1E1;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    asram_bridge u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_bsel_n(mem_bsel_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- memory model ----------------
    logic [15:0] mem [int];
    logic rd_cond, mdrive = 1'b0;
    int tok = 0;

    function automatic logic [15:0] mem_rd(input logic [17:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    assign rd_cond = (mem_ce_n == 1'b0) && (mem_oe_n == 1'b0) && (mem_we_n == 1'b1);

    always @(posedge mem_we_n) begin
        if (mem_ce_n == 1'b0 && mem_dq_oe) begin
            logic [15:0] w;
            w = mem_rd(mem_addr);
            if (!mem_bsel_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_bsel_n[1]) w[15:8] = mem_dq_out[15:8];
            mem[int'(mem_addr)] = w;
        end
    end

    always @(posedge rd_cond) mdrive = 1'b1;
    always @(negedge rd_cond) begin
        #5;
        if (!rd_cond) mdrive = 1'b0;
    end

    always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or mem_bsel_n) begin
        tok++;
        mem_dq_in = 16'hE1E1;
        fork
            begin
                automatic int my = tok;
                #10;
                if (my == tok && rd_cond) begin
                    logic [15:0] v;
                    v = mem_rd(mem_addr);
                    if (mem_bsel_n[0]) v[7:0]  = 8'h5A;
                    if (mem_bsel_n[1]) v[15:8] = 8'h5A;
                    mem_dq_in = v;
                end
            end
        join_none
    end

    // ---------------- monitor ----------------
    int n_we, n_oe, n_ce, n_rdy, n_move = 0, n_hazard = 0;
    int oe_rise = 0, last_gap = -1;
    logic [1:0]  seen_bsel;
    logic [17:0] seen_addr;
    bit prev_ce_lo = 0, prev_oe_lo = 0, prev_dqoe = 0;
    logic [17:0] prev_addr;
    logic [1:0]  prev_bsel;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) n_we++;
            if (!mem_oe_n) n_oe++;
            if (req_ready) n_rdy++;
            if (!mem_ce_n) begin
                n_ce++;
                if (prev_ce_lo && (mem_addr != prev_addr || mem_bsel_n != prev_bsel)) n_move++;
                seen_bsel = mem_bsel_n;
                seen_addr = mem_addr;
            end
            if (!mem_we_n && !mem_oe_n) n_hazard++;
            if (mem_dq_oe && (!mem_oe_n || mdrive)) n_hazard++;
            if (prev_oe_lo && mem_oe_n) oe_rise = cyc;
            if (!prev_dqoe && mem_dq_oe) last_gap = cyc - oe_rise;
            prev_ce_lo = !mem_ce_n;
            prev_oe_lo = !mem_oe_n;
            prev_dqoe  = mem_dq_oe;
            prev_addr  = mem_addr;
            prev_bsel  = mem_bsel_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic tick();
        @(negedge clk);
        #0.5;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] ln, output int lat);
        req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln; req_valid = 1'b1;
        n_we = 0; n_oe = 0; n_ce = 0; n_rdy = 0;
        lat = 0;
        do begin
            tick();
            lat++;
        end while (!req_ready && lat < 60);
        req_valid = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) tick();
        chk("R1", "ce_n", 32'(mem_ce_n), 1);
        chk("R1", "we_n", 32'(mem_we_n), 1);
        chk("R1", "oe_n", 32'(mem_oe_n), 1);
        chk("R1", "bsel_n", 32'(mem_bsel_n), 32'h3);
        chk("R1", "dq_oe/ready", 32'({mem_dq_oe, req_ready}), 0);
        rst_n = 1'b1;
        repeat (2) tick();
    endtask

    task automatic t_full_write_read();
        int lat;
        op(1, 18'h12345, 16'hBEEF, 2'b11, lat);
        chk("R2", "write latency", 32'(lat), WR_LAT);
        chk("R2", "we low cycles", 32'(n_we), WP);
        chk("R2", "oe low during write", 32'(n_oe), 0);
        chk("R11", "ce low cycles >= 3", 32'(n_ce >= 3), 1);
        chk("R3", "both lanes selected", 32'(seen_bsel), 0);
        tick();
        chk("R9", "ready width", 32'(n_rdy), 1);
        tick();
        op(0, 18'h12345, 16'h0, 2'b11, lat);
        chk("R4", "read latency", 32'(lat), RD_LAT);
        chk("R4", "read data", 32'(rsp_rdata), 32'hBEEF);
        chk("R4", "oe low cycles", 32'(n_oe), RD);
        chk("R4", "we low during read", 32'(n_we), 0);
        tick();
        chk("R9", "read ready width", 32'(n_rdy), 1);
        repeat (3) tick();
    endtask

    task automatic t_lanes();
        int lat;
        op(1, 18'h00007, 16'h1122, 2'b11, lat);
        op(1, 18'h00007, 16'hAAFF, 2'b01, lat);
        chk("R3", "lower-only select", 32'(seen_bsel), 32'h2);
        op(0, 18'h00007, 16'h0, 2'b11, lat);
        chk("R3", "lower lane merged", 32'(rsp_rdata), 32'h11FF);
        op(1, 18'h00007, 16'h33CC, 2'b10, lat);
        chk("R3", "upper-only select", 32'(seen_bsel), 32'h1);
        op(0, 18'h00007, 16'h0, 2'b11, lat);
        chk("R3", "upper lane merged", 32'(rsp_rdata), 32'h33FF);
        op(0, 18'h00007, 16'h0, 2'b01, lat);
        chk("R5", "upper lane zeroed", 32'(rsp_rdata), 32'h00FF);
        op(0, 18'h00007, 16'h0, 2'b10, lat);
        chk("R5", "lower lane zeroed", 32'(rsp_rdata), 32'h3300);
        op(0, 18'h00007, 16'h0, 2'b00, lat);
        chk("R5", "no lanes zero", 32'(rsp_rdata), 0);
        chk("R3", "no lanes selected", 32'(seen_bsel), 32'h3);
        repeat (3) tick();
    endtask

    task automatic t_rdata_hold();
        int lat;
        op(0, 18'h12345, 16'h0, 2'b11, lat);
        op(1, 18'h00100, 16'h7777, 2'b11, lat);
        repeat (2) tick();
        chk("R9", "rdata held across write", 32'(rsp_rdata), 32'hBEEF);
        repeat (2) tick();
    endtask

    task automatic t_turnaround();
        int lat;
        op(0, 18'h12345, 16'h0, 2'b11, lat);
        op(1, 18'h00200, 16'h5AA5, 2'b11, lat);
        chk("R7", "oe rise to drive gap", 32'(last_gap), TA + 1);
        chk("R7", "write after read latency", 32'(lat), WR_LAT + 2);
        op(0, 18'h00200, 16'h0, 2'b11, lat);
        chk("R7", "write after read data", 32'(rsp_rdata), 32'h5AA5);
        op(1, 18'h00201, 16'h0102, 2'b11, lat);
        op(1, 18'h00202, 16'h0304, 2'b11, lat);
        chk("R8", "write after write latency", 32'(lat), WR_LAT + 1);
        op(0, 18'h00201, 16'h0, 2'b11, lat);
        repeat (TA + 1) tick();
        op(1, 18'h00203, 16'h0506, 2'b11, lat);
        chk("R8", "write after idle read latency", 32'(lat), WR_LAT);
        op(0, 18'h00202, 16'h0, 2'b11, lat);
        chk("R8", "back-to-back write data", 32'(rsp_rdata), 32'h0304);
        repeat (3) tick();
    endtask

    task automatic t_addr_edges();
        int lat;
        op(1, 18'h3FFFF, 16'h0F0F, 2'b11, lat);
        chk("R10", "top address on pins", 32'(seen_addr), 32'h3FFFF);
        op(1, 18'h00000, 16'hF0F0, 2'b11, lat);
        op(0, 18'h3FFFF, 16'h0, 2'b11, lat);
        chk("R10", "top word readback", 32'(rsp_rdata), 32'h0F0F);
        op(0, 18'h00000, 16'h0, 2'b11, lat);
        chk("R10", "word zero readback", 32'(rsp_rdata), 32'hF0F0);
        repeat (3) tick();
    endtask

    // ---------------- main ----------------
    initial begin
        t_reset();
        t_full_write_read();
        t_lanes();
        t_rdata_hold();
        t_turnaround();
        t_addr_edges();
        chk("R10", "address/select moves while selected", 32'(n_move), 0);
        chk("R6", "strobe overlap or bus contention", 32'(n_hazard), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule